// File: doc/BRIEF.md
# Taken-Branch Target Buffer

This block sits beside the fetch program counter and predicts, from that address alone, where fetch goes next. Each fetch address is looked up in the same cycle against a small direct-mapped table. A hit marks the fetched word as a taken branch before any decode has run, and the block drives the stored destination as the next fetch address. A miss means fall through, and the next fetch address is the current one plus the instruction size. The table holds only branches that were last seen taken, so a hit always stands for a taken prediction.

A later pipeline stage reports each executed branch on the resolve port. It gives the branch address, the actual direction and destination, and what fetch predicted for that branch. A taken branch is written into the table: it takes the slot if it is absent, or refreshes the destination if it is present. A not-taken branch that is present is removed. The same port flags a misprediction in the same cycle so that the pipeline can flush.

Both sides are qualified by a valid pin only and there is no back-pressure. A lookup is answered combinationally in the cycle it is presented. A resolve report is always taken and is committed at the next clock edge.

Top module: `taken_target_buf`

## Requirements
- R1: A synchronous reset, active high, clears every valid bit, so any lookup made after it misses.
- R2: The lookup is combinational from `fetch_pc`. The index is PC bits [5:2] and the tag is PC bits [31:6]. `pred_taken` is 1 only when `fetch_valid` is 1 and the indexed entry is valid with an equal tag.
- R3: On a miss, or when `fetch_valid` is 0, `pred_taken` is 0 and `next_pc` equals `fetch_pc + 4`.
- R4: After a taken resolve for an address that was absent, a lookup of that address in the next cycle hits and returns exactly the reported destination.
- R5: A taken resolve for an address that is present overwrites its stored destination.
- R6: A not-taken resolve for an address that is present invalidates it. A not-taken resolve that misses, including one that shares an index with another branch under a different tag, leaves the table unchanged.
- R7: A taken resolve whose index holds a different tag replaces that entry, and the old branch then misses.
- R8: When a lookup and a resolve write reach the same entry in one cycle, the lookup returns the contents from before the write.
- R9: `mispredict` is 1 when `res_valid` is 1 and either the directions differ, or both are taken and the destinations differ. It is 0 in every other case, including when both directions are not taken and the destinations differ.
- R10: Entries at different indices are independent, and all 16 can hold branches at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetch_valid | input | 1 | A fetch address is presented |
| fetch_pc | input | 32 | Fetch address |
| pred_taken | output | 1 | Hit: predicted taken branch |
| next_pc | output | 32 | Stored destination on a hit, else fetch_pc + 4 |
| res_valid | input | 1 | A resolved branch is reported |
| res_pc | input | 32 | Address of the resolved branch |
| res_taken | input | 1 | Actual direction |
| res_target | input | 32 | Actual destination |
| res_pred_taken | input | 1 | Direction fetch predicted for it |
| res_pred_target | input | 32 | Destination fetch predicted for it |
| mispredict | output | 1 | Prediction for the resolved branch was wrong |

## Verification
The hardest case to reach is a fetch and a resolve that meet on the same entry in the same cycle. The bench holds a fetch of an already stored branch while, in that same cycle, it reports the branch taken to a new destination. It then expects the old destination at once and the new one in the next cycle. Aliasing is just as hard to reach from the ports. The bench uses two addresses that differ only above bit 5 to show replacement, and to show that a not-taken miss leaves the other branch in place.

// File: rtl/btb_pkg.sv
package btb_pkg;
  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_WRITE = 2'd1,
    ACT_CLEAR = 2'd2
  } btb_act_e;
endpackage

// File: rtl/btb_addr_split.sv
module btb_addr_split #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4,
  parameter int OFS_W = 2,
  localparam int TAG_W = PC_W - IDX_W - OFS_W
) (
  input  logic [PC_W-1:0]  pc,
  output logic [IDX_W-1:0] idx,
  output logic [TAG_W-1:0] tag
);
  assign idx = pc[OFS_W +: IDX_W];
  assign tag = pc[PC_W-1 -: TAG_W];
endmodule

// File: rtl/btb_store.sv
module btb_store #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4,
  parameter int OFS_W = 2,
  localparam int TAG_W   = PC_W - IDX_W - OFS_W,
  localparam int ENTRIES = 1 << IDX_W
) (
  input  logic                clk,
  input  logic                rst,
  // fetch read port
  input  logic [IDX_W-1:0]    rd_idx,
  output logic                rd_valid,
  output logic [TAG_W-1:0]    rd_tag,
  output logic [PC_W-1:0]     rd_tgt,
  // resolve probe port
  input  logic [IDX_W-1:0]    pr_idx,
  output logic                pr_valid,
  output logic [TAG_W-1:0]    pr_tag,
  // write port
  input  btb_pkg::btb_act_e   act,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [TAG_W-1:0]    wr_tag,
  input  logic [PC_W-1:0]     wr_tgt
);
  logic [ENTRIES-1:0] vld_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [PC_W-1:0]    tgt_q [ENTRIES];

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
    end else if (act == btb_pkg::ACT_WRITE) begin
      vld_q[wr_idx] <= 1'b1;
    end else if (act == btb_pkg::ACT_CLEAR) begin
      vld_q[wr_idx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (act == btb_pkg::ACT_WRITE) begin
      tag_q[wr_idx] <= wr_tag;
      tgt_q[wr_idx] <= wr_tgt;
    end
  end

  assign rd_valid = vld_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
  assign rd_tgt   = tgt_q[rd_idx];
  assign pr_valid = vld_q[pr_idx];
  assign pr_tag   = tag_q[pr_idx];
endmodule

// File: rtl/btb_resolve_ctl.sv
module btb_resolve_ctl #(
  parameter int PC_W = 32
) (
  input  logic              res_valid,
  input  logic              res_taken,
  input  logic              res_hit,
  input  logic [PC_W-1:0]   res_target,
  input  logic              res_pred_taken,
  input  logic [PC_W-1:0]   res_pred_target,
  output btb_pkg::btb_act_e act,
  output logic              mispredict
);
  always_comb begin
    act = btb_pkg::ACT_NONE;
    if (res_valid) begin
      if (res_taken)    act = btb_pkg::ACT_WRITE;
      else if (res_hit) act = btb_pkg::ACT_CLEAR;
    end
  end

  logic dir_wrong, tgt_wrong;
  assign dir_wrong  = res_taken != res_pred_taken;
  assign tgt_wrong  = res_taken && res_pred_taken && (res_target != res_pred_target);
  assign mispredict = res_valid && (dir_wrong || tgt_wrong);
endmodule

// File: rtl/taken_target_buf.sv
module taken_target_buf #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4,
  parameter int OFS_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fetch_valid,
  input  logic [PC_W-1:0] fetch_pc,
  output logic            pred_taken,
  output logic [PC_W-1:0] next_pc,
  input  logic            res_valid,
  input  logic [PC_W-1:0] res_pc,
  input  logic            res_taken,
  input  logic [PC_W-1:0] res_target,
  input  logic            res_pred_taken,
  input  logic [PC_W-1:0] res_pred_target,
  output logic            mispredict
);
  localparam int TAG_W = PC_W - IDX_W - OFS_W;
  localparam logic [PC_W-1:0] STEP = PC_W'(1) << OFS_W;

  logic [IDX_W-1:0] f_idx, r_idx;
  logic [TAG_W-1:0] f_tag, r_tag, e_tag, p_tag;
  logic             e_vld, p_vld, r_hit;
  logic [PC_W-1:0]  e_tgt;
  btb_pkg::btb_act_e act;

  btb_addr_split #(.PC_W(PC_W), .IDX_W(IDX_W), .OFS_W(OFS_W)) u_fsplit (
    .pc(fetch_pc), .idx(f_idx), .tag(f_tag));
  btb_addr_split #(.PC_W(PC_W), .IDX_W(IDX_W), .OFS_W(OFS_W)) u_rsplit (
    .pc(res_pc), .idx(r_idx), .tag(r_tag));

  btb_store #(.PC_W(PC_W), .IDX_W(IDX_W), .OFS_W(OFS_W)) u_store (
    .clk(clk), .rst(rst),
    .rd_idx(f_idx), .rd_valid(e_vld), .rd_tag(e_tag), .rd_tgt(e_tgt),
    .pr_idx(r_idx), .pr_valid(p_vld), .pr_tag(p_tag),
    .act(act), .wr_idx(r_idx), .wr_tag(r_tag), .wr_tgt(res_target));

  assign r_hit = p_vld && (p_tag == r_tag);

  btb_resolve_ctl #(.PC_W(PC_W)) u_ctl (
    .res_valid(res_valid), .res_taken(res_taken), .res_hit(r_hit),
    .res_target(res_target), .res_pred_taken(res_pred_taken),
    .res_pred_target(res_pred_target), .act(act), .mispredict(mispredict));

  assign pred_taken = fetch_valid && e_vld && (e_tag == f_tag);
  assign next_pc    = pred_taken ? e_tgt : fetch_pc + STEP;
endmodule

// File: rtl/btb_checks.sv
module btb_checks #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            fetch_valid,
  input logic [PC_W-1:0] fetch_pc,
  input logic            pred_taken,
  input logic [PC_W-1:0] next_pc,
  input logic            res_valid,
  input logic [PC_W-1:0] res_pc,
  input logic            res_taken,
  input logic [PC_W-1:0] res_target,
  input logic            res_pred_taken,
  input logic [PC_W-1:0] res_pred_target,
  input logic            mispredict
);
  // R2
  hit_needs_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    pred_taken |-> fetch_valid);
  // R4
  taken_then_hit_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_taken) |=>
      (!(fetch_valid && fetch_pc == $past(res_pc)) ||
       (pred_taken && next_pc == $past(res_target))));
  // R6
  not_taken_then_miss_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_taken) |=>
      (!(fetch_valid && fetch_pc == $past(res_pc)) || !pred_taken));
  // R9
  dir_wrong_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && (res_taken != res_pred_taken)) |-> mispredict);
  // R9
  idle_no_flag_chk: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> !mispredict);
  // R3
  miss_falls_through_chk: assert property (@(posedge clk) disable iff (rst)
    !pred_taken |-> (next_pc == fetch_pc + PC_W'(4)));
endmodule

bind taken_target_buf btb_checks #(.PC_W(PC_W)) u_chk (.*);

// File: tb/sim_taken_target_buf.sv
module sim_taken_target_buf;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fetch_valid = 1'b0;
  logic [31:0] fetch_pc = '0;
  logic        pred_taken;
  logic [31:0] next_pc;
  logic        res_valid = 1'b0;
  logic [31:0] res_pc = '0;
  logic        res_taken = 1'b0;
  logic [31:0] res_target = '0;
  logic        res_pred_taken = 1'b0;
  logic [31:0] res_pred_target = '0;
  logic        mispredict;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  taken_target_buf u0 (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic resolve(logic [31:0] pc, logic tk, logic [31:0] tgt);
    @(negedge clk);
    res_valid = 1'b1; res_pc = pc; res_taken = tk; res_target = tgt;
    res_pred_taken = tk; res_pred_target = tgt;
    @(posedge clk); #1;
    res_valid = 1'b0;
  endtask

  task automatic look(string req, logic [31:0] pc, logic hit, logic [31:0] nxt);
    @(negedge clk);
    fetch_valid = 1'b1; fetch_pc = pc;
    #1;
    chk(req, {31'd0, pred_taken}, {31'd0, hit});
    chk(req, next_pc, nxt);
    fetch_valid = 1'b0;
  endtask

  task automatic mp(string req, logic tk, logic [31:0] tgt, logic ptk,
                    logic [31:0] ptgt, logic exp);
    @(negedge clk);
    res_valid = 1'b1; res_pc = 32'h0000_7F00; res_taken = tk; res_target = tgt;
    res_pred_taken = ptk; res_pred_target = ptgt;
    #1;
    chk(req, {31'd0, mispredict}, {31'd0, exp});
    @(posedge clk); #1;
    res_valid = 1'b0;
  endtask

  task automatic t_reset();
    // R1
    look("R1", 32'h0000_1008, 1'b0, 32'h0000_100C);
    // R3
    @(negedge clk); fetch_valid = 1'b0; fetch_pc = 32'h0000_2000; #1;
    chk("R3", {31'd0, pred_taken}, 32'd0);
    chk("R3", next_pc, 32'h0000_2004);
  endtask

  task automatic t_alloc_update();
    resolve(32'h0000_1008, 1'b1, 32'h0000_4000);
    look("R4", 32'h0000_1008, 1'b1, 32'h0000_4000);
    // R2: same index, different tag misses
    look("R2", 32'h0000_2008, 1'b0, 32'h0000_200C);
    // R5
    resolve(32'h0000_1008, 1'b1, 32'h0000_5550);
    look("R5", 32'h0000_1008, 1'b1, 32'h0000_5550);
  endtask

  task automatic t_alias_invalidate();
    // R6: not-taken miss on alias leaves entry
    resolve(32'h0000_2008, 1'b0, 32'h0);
    look("R6", 32'h0000_1008, 1'b1, 32'h0000_5550);
    // R7: taken alias replaces
    resolve(32'h0000_2008, 1'b1, 32'h0000_6000);
    look("R7", 32'h0000_1008, 1'b0, 32'h0000_100C);
    look("R7", 32'h0000_2008, 1'b1, 32'h0000_6000);
    // R6: not-taken hit invalidates
    resolve(32'h0000_2008, 1'b0, 32'h0);
    look("R6", 32'h0000_2008, 1'b0, 32'h0000_200C);
  endtask

  task automatic t_same_cycle();
    resolve(32'h0000_3010, 1'b1, 32'h0000_A000);
    @(negedge clk);
    fetch_valid = 1'b1; fetch_pc = 32'h0000_3010;
    res_valid = 1'b1; res_pc = 32'h0000_3010; res_taken = 1'b1;
    res_target = 32'h0000_B000; res_pred_taken = 1'b1; res_pred_target = 32'h0000_A000;
    #1;
    // R8
    chk("R8", next_pc, 32'h0000_A000);
    @(posedge clk); #1;
    res_valid = 1'b0; fetch_valid = 1'b0;
    look("R8", 32'h0000_3010, 1'b1, 32'h0000_B000);
  endtask

  task automatic t_mispredict();
    // R9
    mp("R9", 1'b1, 32'h100, 1'b1, 32'h100, 1'b0);
    mp("R9", 1'b1, 32'h100, 1'b1, 32'h104, 1'b1);
    mp("R9", 1'b1, 32'h100, 1'b0, 32'h100, 1'b1);
    mp("R9", 1'b0, 32'h100, 1'b1, 32'h100, 1'b1);
    mp("R9", 1'b0, 32'h100, 1'b0, 32'h200, 1'b0);
    @(negedge clk); #1;
    chk("R9", {31'd0, mispredict}, 32'd0);
  endtask

  task automatic t_fill();
    // R10
    for (int i = 0; i < 16; i++)
      resolve(32'h0008_0000 | (i << 2), 1'b1, 32'h0009_0000 + i * 32'h40);
    for (int i = 0; i < 16; i++)
      look("R10", 32'h0008_0000 | (i << 2), 1'b1, 32'h0009_0000 + i * 32'h40);
    // R1: reset clears all
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    look("R1", 32'h0008_0004, 1'b0, 32'h0008_0008);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_alloc_update();
    t_alias_invalidate();
    t_same_cycle();
    t_mispredict();
    t_fill();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule